// File: doc/BRIEF.md
# Indirect Register and Memory Window

This block lets a host reach two internal spaces through a handful of directly mapped registers. The first is a register space that is always reachable. The second is an on-chip SRAM, which is reachable only while its power domain is awake.

For the register space, the host uses a control register and a data register. Writing the control register with a read or write opcode starts a single internal transaction on the offset held in that write. A read transaction leaves its result in the data register.

For the SRAM, the host uses a read pointer and a write pointer. Each pointer serves its own data register, and each access to that data register moves the pointer forward by one dword. Every internal transaction goes out on a single request/acknowledge port, and only one transaction is outstanding at a time. While it is outstanding, every host access is held off.

Top module: `ind_window`

Host register selects (host_addr): 0 shared control, 1 shared data, 2 memory read pointer, 3 memory write pointer, 4 memory write data, 5 memory read data. Any other select reads as zero and ignores writes.

## Requirements
- R1: After reset, host_ready is 1, int_req is 0 and host_rvalid is 0, and both memory pointers read back as 0.
- R2: Writing the shared control register with bits 29:28 equal to 3 issues one internal write (int_space 0, int_we 1) carrying the value held in the shared data register.
- R3: Writing the shared control register with bits 29:28 equal to 2 issues one internal read (int_space 0, int_we 0), and the returned word is then read from the shared data register.
- R4: A shared control write whose bits 29:28 are 0 or 1 issues no internal transaction and leaves the shared data register unchanged.
- R5: Shared transactions are issued whatever the level of mem_grant.
- R6: The internal offset of a shared transaction is bits 15:0 of the control write, zero-extended. Higher bits of the control write, other than 29:28, have no effect on the transaction.
- R7: With mem_grant high, each write to the memory write data register issues an internal write (int_space 1) at the write pointer, and the write pointer then advances by 4.
- R8: With mem_grant high, each read of the memory read data register issues an internal read at the read pointer and returns the acknowledged word on host_rdata with host_rvalid. The read pointer then advances by 4.
- R9: The read pointer and the write pointer are loaded and advanced independently of each other.
- R10: A memory read data access with mem_grant low returns 32'hFFFFFFFF at once, issues no internal transaction and does not move the read pointer.
- R11: A memory write data access with mem_grant low is dropped: no internal transaction takes place and the write pointer does not move.
- R12: While an internal transaction is outstanding, host_ready is 0 and int_req stays high with a stable address until int_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 for a host write, 0 for a host read |
| host_addr | input | HA_W | Host register select |
| host_wdata | input | DATA_W | Host write data |
| host_ready | output | 1 | Access accepted on a clock edge where host_req is 1 and this is 1 |
| host_rvalid | output | 1 | One-cycle pulse marking host read data |
| host_rdata | output | DATA_W | Host read data |
| mem_grant | input | 1 | Wake access grant for the memory window |
| int_req | output | 1 | Internal transaction outstanding |
| int_space | output | 1 | 0 shared register space, 1 SRAM |
| int_we | output | 1 | Internal write when 1 |
| int_addr | output | ADDR_W | Internal address or offset |
| int_wdata | output | DATA_W | Internal write data |
| int_ack | input | 1 | Internal transaction completed (one cycle) |
| int_rdata | input | DATA_W | Internal read data, valid with int_ack |

## Verification
The bench uses the default widths (32-bit data and addresses, a 16-bit offset field, a 4-byte step). It pairs them with a responder that waits three cycles before acknowledging. That latency makes the stall window wide enough to observe the host being held off across several edges. Pointer walks across consecutive dwords, offsets whose upper control bits are set, and every grant-low path are checked against a behavioural model of both spaces.

// File: rtl/ind_window.sv
module ind_window #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16,
  parameter int HA_W   = 3,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              mem_grant,
  output logic              int_req,
  output logic              int_space,
  output logic              int_we,
  output logic [ADDR_W-1:0] int_addr,
  output logic [DATA_W-1:0] int_wdata,
  input  logic              int_ack,
  input  logic [DATA_W-1:0] int_rdata
);
  localparam logic [HA_W-1:0] SEL_SCTL = HA_W'(0);
  localparam logic [HA_W-1:0] SEL_SDAT = HA_W'(1);
  localparam logic [HA_W-1:0] SEL_RPTR = HA_W'(2);
  localparam logic [HA_W-1:0] SEL_WPTR = HA_W'(3);
  localparam logic [HA_W-1:0] SEL_WDAT = HA_W'(4);
  localparam logic [HA_W-1:0] SEL_RDAT = HA_W'(5);
  localparam logic [1:0] OP_RD = 2'd2;
  localparam logic [1:0] OP_WR = 2'd3;

  logic [DATA_W-1:0] sctl, sdat, rd_mux;
  logic [ADDR_W-1:0] rptr, wptr;
  logic [1:0] op;
  logic acc;

  assign host_ready = !int_req;
  assign acc = host_req && host_ready;
  assign op = host_wdata[29:28];

  always_comb begin
    case (host_addr)
      SEL_SCTL: rd_mux = sctl;
      SEL_SDAT: rd_mux = sdat;
      SEL_RPTR: rd_mux = DATA_W'(rptr);
      SEL_WPTR: rd_mux = DATA_W'(wptr);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sctl <= '0; sdat <= '0; rptr <= '0; wptr <= '0;
      int_req <= 1'b0; int_space <= 1'b0; int_we <= 1'b0;
      int_addr <= '0; int_wdata <= '0;
      host_rvalid <= 1'b0; host_rdata <= '0;
    end else begin
      host_rvalid <= 1'b0;
      if (int_req && int_ack) begin
        int_req <= 1'b0;
        if (!int_space) begin
          if (!int_we) sdat <= int_rdata;
        end else if (int_we) begin
          wptr <= wptr + ADDR_W'(STEP);
        end else begin
          rptr <= rptr + ADDR_W'(STEP);
          host_rvalid <= 1'b1;
          host_rdata <= int_rdata;
        end
      end else if (acc && host_we) begin
        case (host_addr)
          SEL_SCTL: begin
            sctl <= host_wdata;
            if (op == OP_RD || op == OP_WR) begin
              int_req   <= 1'b1;
              int_space <= 1'b0;
              int_we    <= (op == OP_WR);
              int_addr  <= ADDR_W'(host_wdata[OFS_W-1:0]);
              int_wdata <= sdat;
            end
          end
          SEL_SDAT: sdat <= host_wdata;
          SEL_RPTR: rptr <= ADDR_W'(host_wdata);
          SEL_WPTR: wptr <= ADDR_W'(host_wdata);
          SEL_WDAT: if (mem_grant) begin
            int_req   <= 1'b1;
            int_space <= 1'b1;
            int_we    <= 1'b1;
            int_addr  <= wptr;
            int_wdata <= host_wdata;
          end
          default: ;
        endcase
      end else if (acc) begin
        if (host_addr == SEL_RDAT) begin
          if (mem_grant) begin
            int_req   <= 1'b1;
            int_space <= 1'b1;
            int_we    <= 1'b0;
            int_addr  <= rptr;
          end else begin
            host_rvalid <= 1'b1;
            host_rdata  <= '1;
          end
        end else begin
          host_rvalid <= 1'b1;
          host_rdata  <= rd_mux;
        end
      end
    end
  end

  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> !host_ready); // R12
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && !int_ack) |=> (int_req && $stable(int_addr))); // R12
  AST_MEM_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(int_req) && int_space) |-> $past(mem_grant)); // R10
  AST_SHR_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(int_req) && !int_space) |-> (int_addr >> OFS_W) == '0); // R6
  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int_ack && int_space && int_we) |=> wptr == $past(wptr) + ADDR_W'(STEP)); // R7
  AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int_ack && int_space && !int_we) |=> (rptr == $past(rptr) + ADDR_W'(STEP)) && host_rvalid); // R8
endmodule

// File: tb/ind_window_bench.sv
module ind_window_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0, mem_grant = 1'b0;
  logic [2:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic host_ready, host_rvalid, int_req, int_space, int_we;
  logic [31:0] host_rdata, int_addr, int_wdata;
  logic int_ack;
  logic [31:0] int_rdata;

  int checks = 0, fails = 0, txn_cnt = 0, cnt = 0;
  logic [31:0] shr_mem [logic [31:0]];
  logic [31:0] sram [logic [31:0]];
  logic [31:0] last_addr;
  logic last_space, last_we;

  always #(CLK_PERIOD/2) clk = ~clk;

  ind_window u_ind_window (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata), .mem_grant(mem_grant),
    .int_req(int_req), .int_space(int_space), .int_we(int_we), .int_addr(int_addr),
    .int_wdata(int_wdata), .int_ack(int_ack), .int_rdata(int_rdata)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_ack <= 1'b0; int_rdata <= '0; cnt <= 0;
    end else begin
      int_ack <= 1'b0;
      if (int_req && int_ack) txn_cnt = txn_cnt + 1;
      if (int_req && !int_ack) begin
        if (cnt == LAT) begin
          int_ack <= 1'b1; cnt <= 0;
          last_addr = int_addr; last_space = int_space; last_we = int_we;
          if (int_space) begin
            if (int_we) sram[int_addr] = int_wdata;
            else int_rdata <= sram.exists(int_addr) ? sram[int_addr] : 32'hDEAD0000;
          end else begin
            if (int_we) shr_mem[int_addr] = int_wdata;
            else int_rdata <= shr_mem.exists(int_addr) ? shr_mem[int_addr] : 32'hBEEF0000;
          end
        end else cnt <= cnt + 1;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R12: per-cycle reference of the stall rule against the responder's view
  always @(negedge clk) if (rst_n) begin
    if (int_req) check("R12 stall", {31'b0, host_ready}, 32'h0);
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    while (!host_ready) @(negedge clk);
    @(negedge clk); host_req = 1'b0;
    while (int_req) @(negedge clk);
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); host_req = 1'b1; host_we = 1'b0; host_addr = a;
    while (!host_ready) @(negedge clk);
    @(negedge clk); host_req = 1'b0;
    while (!host_rvalid) @(negedge clk);
    d = host_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n0;
    repeat (3) @(negedge clk);
    check("R1 ready", {31'b0, host_ready}, 32'h1);
    check("R1 req", {31'b0, int_req}, 32'h0);
    check("R1 rvalid", {31'b0, host_rvalid}, 32'h0);
    rst_n = 1'b1;
    rd(3'd2, v); check("R1 rptr", v, 32'h0);
    rd(3'd3, v); check("R1 wptr", v, 32'h0);

    // R2, R5: shared write with grant low
    wr(3'd1, 32'hA5A5_5A5A);
    n0 = txn_cnt;
    wr(3'd0, 32'h3000_01DC);
    check("R2 one txn", txn_cnt - n0, 1);
    check("R2 space/we", {30'b0, last_space, last_we}, 32'h1);
    check("R5 R2 stored", shr_mem.exists(32'h1DC) ? shr_mem[32'h1DC] : 32'hX, 32'hA5A5_5A5A);

    // R3: shared read
    shr_mem[32'h40] = 32'h1234_5678;
    wr(3'd0, 32'h2000_0040);
    check("R3 space/we", {30'b0, last_space, last_we}, 32'h0);
    rd(3'd1, v); check("R3 data", v, 32'h1234_5678);

    // R4: opcodes 0 and 1 ignored
    n0 = txn_cnt;
    wr(3'd0, 32'h1000_0040);
    wr(3'd0, 32'h0000_01DC);
    check("R4 no txn", txn_cnt - n0, 0);
    rd(3'd1, v); check("R4 data kept", v, 32'h1234_5678);

    // R6: upper control bits do not leak into the offset
    shr_mem[32'h0ABC] = 32'h0C0F_FEE0;
    wr(3'd0, 32'h2FFF_0ABC);
    check("R6 offset", last_addr, 32'h0000_0ABC);
    rd(3'd1, v); check("R6 data", v, 32'h0C0F_FEE0);

    // R7: memory writes with grant
    mem_grant = 1'b1;
    wr(3'd3, 32'h100);
    for (int i = 0; i < 3; i++) wr(3'd4, 32'h5000 + i);
    for (int i = 0; i < 3; i++)
      check("R7 sram", sram.exists(32'h100 + 4*i) ? sram[32'h100 + 4*i] : 32'hX, 32'h5000 + i);
    rd(3'd3, v); check("R7 wptr", v, 32'h10C);

    // R8, R9: reads walk their own pointer
    wr(3'd2, 32'h104);
    rd(3'd3, v); check("R9 wptr untouched", v, 32'h10C);
    for (int i = 1; i < 3; i++) begin
      rd(3'd5, v); check("R8 rdata", v, 32'h5000 + i);
    end
    rd(3'd2, v); check("R8 rptr", v, 32'h10C);
    rd(3'd3, v); check("R9 wptr", v, 32'h10C);

    // R10: read with grant low
    mem_grant = 1'b0;
    n0 = txn_cnt;
    rd(3'd5, v); check("R10 ones", v, 32'hFFFF_FFFF);
    check("R10 no txn", txn_cnt - n0, 0);
    rd(3'd2, v); check("R10 rptr", v, 32'h10C);

    // R11: write with grant low
    wr(3'd4, 32'hDEAD_BEEF);
    check("R11 no txn", txn_cnt - n0, 0);
    check("R11 sram", {31'b0, sram.exists(32'h10C)}, 32'h0);
    rd(3'd3, v); check("R11 wptr", v, 32'h10C);

    // R5: shared read still works with grant low
    wr(3'd0, 32'h2000_01DC);
    rd(3'd1, v); check("R5 data", v, 32'hA5A5_5A5A);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule